// File: doc/BRIEF.md
# Main-to-Sound Command Mailbox

This block passes one command byte from a 16-bit main processor to an 8-bit sound processor, and one reply byte back the other way. The main side uses only the upper byte lane of its data bus (bits 15..8, the even-address byte). A qualified main-side write stores that byte in a command register, marks it pending and, once the write strobe ends, raises a one-clock notify pulse. An external interrupt generator uses that pulse to interrupt the sound processor.

The sound processor reads the command through its own read strobe, and the first cycle of that read drops the pending mark. It writes a reply byte through a separate write strobe. The main side reads that reply, or a status byte that carries the pending mark, on the upper lane. A separate clear strobe empties the command register.

Address decoding is done outside the block. It receives one select strobe per access type, and all strobes are synchronous to `clk`.

Top module: `sndcmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the command byte, reply byte and pending mark are zero, `sndcmd_notify` is low, and both read outputs return zero.
- R2: In a cycle where `host_wr_stb` and `host_ube` are both high, `host_d_hi` is stored as the command. While `snd_rd_stb` is high, `snd_dout` shows the stored command. Otherwise it shows zero.
- R3: A write with `host_ube` low is ignored. It changes neither the command nor the pending mark, and it produces no notify pulse.
- R4: `sndcmd_notify` is high for exactly one clock per write, in the second cycle after the last cycle in which the qualified write strobe was high, whatever the strobe's length.
- R5: A qualified write sets the pending mark. The first cycle of a sound read clears it, and it stays clear while that read strobe is held.
- R6: `cmd_clr` sets the command byte to zero and clears the pending mark. The reply byte is unaffected.
- R7: When `cmd_clr` and a qualified write fall in the same cycle, the write wins: the command takes `host_d_hi` and the mark is set.
- R8: When the first cycle of a sound read coincides with a qualified write, the write wins and the pending mark stays set.
- R9: `snd_wr_stb` stores `snd_din` as the reply. The reply holds until the next sound write. While `host_rd_sel` is high, `host_q_hi` shows the reply.
- R10: While `host_stat_sel` is high, `host_q_hi` shows the pending mark in bit 7 with all other bits zero. This takes precedence over `host_rd_sel`. With neither select high, `host_q_hi` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both processor interfaces |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_stb | input | 1 | Decoded main-side write select |
| host_ube | input | 1 | Main-side upper byte lane enable |
| host_d_hi | input | 8 | Main data bus bits 15..8 (write data) |
| host_rd_sel | input | 1 | Decoded main-side reply read select |
| host_stat_sel | input | 1 | Decoded main-side status read select |
| host_q_hi | output | 8 | Read data for main bus bits 15..8 |
| snd_rd_stb | input | 1 | Sound-side command read strobe |
| snd_wr_stb | input | 1 | Sound-side reply write strobe |
| snd_din | input | 8 | Sound-side write data |
| snd_dout | output | 8 | Sound-side read data |
| cmd_clr | input | 1 | Clears the stored command byte |
| sndcmd_notify | output | 1 | One-clock pulse after a completed main write |

## Verification
A main write can land in the same clock as either of two events that change the pending mark: a command clear, or the opening cycle of a sound read. The bench provokes each collision by raising both strobes at the same falling clock edge, so that one rising edge sees both. Afterwards it judges the winner through the normal interfaces: the status read must show the mark set, and a sound read must return the newly written byte rather than zero or the old value.

// File: rtl/mbox_pkg.sv
// Package: shared types for the command mailbox.
// Assumes every strobe is synchronous to the block clock.
package mbox_pkg;

    // Events that act on the command slot in one clock.
    typedef struct packed {
        logic wr;        // qualified main-side write this cycle
        logic clr;       // clear request this cycle
        logic rd_start;  // first cycle of a sound-side read
    } slot_ev_t;

    localparam int unsigned MBOX_BYTE_W = 8;

endpackage

// File: rtl/mbox_strobe_edge.sv
// Module: mbox_strobe_edge
// Registers a level strobe and reports its rising and falling cycles.
// Assumes the strobe is synchronous. rise/fall are combinational from
// the current level and the registered copy.
module mbox_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_q;

    // Keep last cycle's level of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/mbox_cmd_slot.sv
// Module: mbox_cmd_slot
// Holds the command byte, its pending mark and the notify pulse.
// Priority inside one cycle: write over clear, write over read-start.
// Assumes wr_fall marks the first cycle after a qualified write ended.
module mbox_cmd_slot
    import mbox_pkg::*;
#(
    parameter int unsigned W = MBOX_BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slot_ev_t     ev,
    input  logic         wr_fall,
    input  logic [W-1:0] din,
    output logic [W-1:0] cmd,
    output logic         pending,
    output logic         notify
);

    // Command register: write wins, otherwise clear empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= '0;
        else if (ev.wr)  cmd <= din;
        else if (ev.clr) cmd <= '0;
    end

    // Pending mark: set by write, dropped by clear or read start.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pending <= 1'b0;
        else if (ev.wr)                   pending <= 1'b1;
        else if (ev.clr || ev.rd_start)   pending <= 1'b0;
    end

    // Notify: one registered pulse after the write strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) notify <= 1'b0;
        else        notify <= wr_fall;
    end

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev.wr |=> (pending && cmd == $past(din)));

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.clr && !ev.wr) |=> (cmd == '0 && !pending));

    p_read_drops_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.rd_start && !ev.wr) |=> !pending);

    p_read_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.rd_start && ev.wr) |=> pending);

    p_notify_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        notify |=> !notify);

endmodule

// File: rtl/mbox_reply_slot.sv
// Module: mbox_reply_slot
// Stores the sound-side reply byte until the next sound write.
// Assumes the write strobe is qualified by the sound-side decoder.
module mbox_reply_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] reply
);

    // Reply register: loads on each sound write.
    always_ff @(posedge clk) begin
        if (!rst_n)  reply <= '0;
        else if (wr) reply <= din;
    end

    p_reply_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(reply));

    p_reply_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> reply == $past(din));

endmodule

// File: rtl/sndcmd_mailbox.sv
// Module: sndcmd_mailbox (top)
// One-byte command mailbox from a 16-bit main CPU (upper byte lane
// only) to an 8-bit sound CPU, with a reply byte going back.
// Assumes pre-decoded, clock-synchronous select strobes.
module sndcmd_mailbox
    import mbox_pkg::*;
#(
    parameter int unsigned BYTE_W   = MBOX_BYTE_W,
    parameter int unsigned STAT_POS = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_stb,
    input  logic              host_ube,
    input  logic [BYTE_W-1:0] host_d_hi,
    input  logic              host_rd_sel,
    input  logic              host_stat_sel,
    output logic [BYTE_W-1:0] host_q_hi,
    input  logic              snd_rd_stb,
    input  logic              snd_wr_stb,
    input  logic [BYTE_W-1:0] snd_din,
    output logic [BYTE_W-1:0] snd_dout,
    input  logic              cmd_clr,
    output logic              sndcmd_notify
);

    localparam logic [BYTE_W-1:0] ZERO_B = '0;

    logic              wr_act;
    logic              wr_rise_unused;
    logic              wr_fall;
    logic              rd_rise;
    logic              rd_fall_unused;
    slot_ev_t          ev;
    logic [BYTE_W-1:0] cmd_q;
    logic              pend_q;
    logic [BYTE_W-1:0] reply_q;
    logic [BYTE_W-1:0] stat_b;

    assign wr_act = host_wr_stb & host_ube;

    mbox_strobe_edge u_wr_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (wr_act),
        .rise  (wr_rise_unused),
        .fall  (wr_fall)
    );

    mbox_strobe_edge u_rd_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (snd_rd_stb),
        .rise  (rd_rise),
        .fall  (rd_fall_unused)
    );

    // Gather this cycle's slot events.
    always_comb begin
        ev.wr       = wr_act;
        ev.clr      = cmd_clr;
        ev.rd_start = rd_rise;
    end

    mbox_cmd_slot #(.W(BYTE_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_fall (wr_fall),
        .din     (host_d_hi),
        .cmd     (cmd_q),
        .pending (pend_q),
        .notify  (sndcmd_notify)
    );

    mbox_reply_slot #(.W(BYTE_W)) u_reply (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (snd_wr_stb),
        .din   (snd_din),
        .reply (reply_q)
    );

    // Status byte: pending mark at its fixed bit, all else zero.
    always_comb begin
        stat_b           = ZERO_B;
        stat_b[STAT_POS] = pend_q;
    end

    // Main-side read mux: status over reply, zero when idle.
    always_comb begin
        if (host_stat_sel)    host_q_hi = stat_b;
        else if (host_rd_sel) host_q_hi = reply_q;
        else                  host_q_hi = ZERO_B;
    end

    // Sound-side read data: the command while reading, else zero.
    assign snd_dout = snd_rd_stb ? cmd_q : ZERO_B;

    p_lower_lane_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_stb && !host_ube && !cmd_clr) |=> $stable(cmd_q));

    p_notify_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sndcmd_notify |-> ($past(host_wr_stb && host_ube, 2)
                           && !$past(host_wr_stb && host_ube, 1)));

    p_status_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_stat_sel |-> ($countones(host_q_hi) <= 1));

endmodule

// File: tb/test_sndcmd_mailbox.sv
module test_sndcmd_mailbox;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_stb = 1'b0;
    logic       host_ube = 1'b0;
    logic [7:0] host_d_hi = 8'h00;
    logic       host_rd_sel = 1'b0;
    logic       host_stat_sel = 1'b0;
    logic [7:0] host_q_hi;
    logic       snd_rd_stb = 1'b0;
    logic       snd_wr_stb = 1'b0;
    logic [7:0] snd_din = 8'h00;
    logic [7:0] snd_dout;
    logic       cmd_clr = 1'b0;
    logic       sndcmd_notify;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sndcmd_mailbox i_sndcmd_mailbox (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_stb   (host_wr_stb),
        .host_ube      (host_ube),
        .host_d_hi     (host_d_hi),
        .host_rd_sel   (host_rd_sel),
        .host_stat_sel (host_stat_sel),
        .host_q_hi     (host_q_hi),
        .snd_rd_stb    (snd_rd_stb),
        .snd_wr_stb    (snd_wr_stb),
        .snd_din       (snd_din),
        .snd_dout      (snd_dout),
        .cmd_clr       (cmd_clr),
        .sndcmd_notify (sndcmd_notify)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Status byte read through the main side (pending in bit 7).
    task automatic read_status(output logic [7:0] v);
        host_stat_sel = 1'b1; #1; v = host_q_hi; host_stat_sel = 1'b0; #1;
    endtask

    task automatic read_reply(output logic [7:0] v);
        host_rd_sel = 1'b1; #1; v = host_q_hi; host_rd_sel = 1'b0; #1;
    endtask

    // One-cycle sound read; returns data seen, pending cleared after.
    task automatic snd_read(output logic [7:0] v);
        @(negedge clk); snd_rd_stb = 1'b1; #1; v = snd_dout;
        @(negedge clk); snd_rd_stb = 1'b0;
    endtask

    // Main write held for n cycles; checks notify timing (R4).
    task automatic host_write(input logic [7:0] d, input logic ube, input int n,
                              input logic expect_pulse);
        @(negedge clk);
        host_wr_stb = 1'b1; host_ube = ube; host_d_hi = d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R4 no notify during strobe", {7'b0, sndcmd_notify}, 8'h00);
        end
        host_wr_stb = 1'b0; host_ube = 1'b0;
        @(negedge clk);
        check("R4 notify pulse", {7'b0, sndcmd_notify}, {7'b0, expect_pulse});
        @(negedge clk);
        check("R4 notify one cycle", {7'b0, sndcmd_notify}, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 notify", {7'b0, sndcmd_notify}, 8'h00);
        check("R1 idle host_q", host_q_hi, 8'h00);
        read_status(v);  check("R1 status", v, 8'h00);
        read_reply(v);   check("R1 reply", v, 8'h00);
        snd_read(v);     check("R1 cmd", v, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        host_write(8'h5A, 1'b1, 1, 1'b1);
        read_status(v);  check("R5 pending set", v, 8'h80);
        check("R2 snd_dout zero when idle", snd_dout, 8'h00);
        @(negedge clk); snd_rd_stb = 1'b1; #1;
        check("R2 command seen", snd_dout, 8'h5A);
        @(negedge clk); @(negedge clk);
        read_status(v);  check("R5 cleared while read held", v, 8'h00);
        snd_rd_stb = 1'b0;
        host_write(8'hC3, 1'b1, 4, 1'b1);
        snd_read(v);     check("R2 second pattern", v, 8'hC3);
    endtask

    task automatic t_lower_lane;
        logic [7:0] v;
        host_write(8'hFF, 1'b0, 2, 1'b0);
        read_status(v);  check("R3 no pending", v, 8'h00);
        snd_read(v);     check("R3 command unchanged", v, 8'hC3);
    endtask

    task automatic t_reply;
        logic [7:0] v;
        @(negedge clk); snd_wr_stb = 1'b1; snd_din = 8'hA5;
        @(negedge clk); snd_wr_stb = 1'b0; snd_din = 8'h11;
        repeat (2) @(negedge clk);
        read_reply(v);   check("R9 reply read", v, 8'hA5);
        @(negedge clk); snd_wr_stb = 1'b1; snd_din = 8'h3C;
        @(negedge clk); snd_wr_stb = 1'b0;
        read_reply(v);   check("R9 reply overwrite", v, 8'h3C);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        host_write(8'h77, 1'b1, 1, 1'b1);
        @(negedge clk); cmd_clr = 1'b1;
        @(negedge clk); cmd_clr = 1'b0;
        read_status(v);  check("R6 pending cleared", v, 8'h00);
        read_reply(v);   check("R6 reply kept", v, 8'h3C);
        snd_read(v);     check("R6 command zero", v, 8'h00);
    endtask

    task automatic t_clear_vs_write;
        logic [7:0] v;
        @(negedge clk);
        host_wr_stb = 1'b1; host_ube = 1'b1; host_d_hi = 8'h96; cmd_clr = 1'b1;
        @(negedge clk);
        host_wr_stb = 1'b0; host_ube = 1'b0; cmd_clr = 1'b0;
        read_status(v);  check("R7 pending kept", v, 8'h80);
        snd_read(v);     check("R7 write wins", v, 8'h96);
    endtask

    task automatic t_read_vs_write;
        logic [7:0] v;
        read_status(v);  check("R8 pending clear before", v, 8'h00);
        @(negedge clk);
        host_wr_stb = 1'b1; host_ube = 1'b1; host_d_hi = 8'h4E; snd_rd_stb = 1'b1;
        @(negedge clk);
        host_wr_stb = 1'b0; host_ube = 1'b0;
        read_status(v);  check("R8 write beats read", v, 8'h80);
        #1; check("R8 new command visible", snd_dout, 8'h4E);
        @(negedge clk); snd_rd_stb = 1'b0;
        read_status(v);  check("R8 held read does not clear", v, 8'h80);
    endtask

    task automatic t_status_priority;
        logic [7:0] v;
        host_rd_sel = 1'b1; host_stat_sel = 1'b1; #1; v = host_q_hi;
        host_rd_sel = 1'b0; host_stat_sel = 1'b0; #1;
        check("R10 status over reply", v, 8'h80);
        check("R10 idle zero", host_q_hi, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_lower_lane();
        t_reply();
        t_clear();
        t_clear_vs_write();
        t_read_vs_write();
        t_status_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule